// File: doc/BRIEF.md
# Device ROM Header Validator

This block checks the fixed header at the front of a device ROM image. The image arrives as a byte stream, one byte per clock, starting with byte 0. The block does not fetch bytes and does not walk the entry list after the header. While the bytes stream past, it captures the header fields. It runs an 8-bit CRC over the 64-bit unique identifier and a 32-bit Castagnoli CRC over the data region. It also works out the total image length from a 10-bit length field stored inside the image.

When the image is complete, or when the stream ends or proves the image unusable, the block raises a one-cycle `done_o` pulse. Every result output is registered and is held until the next pulse. A failed identifier CRC, a truncated stream, an image shorter than its own header, or a mismatch with an optional externally supplied length is fatal. A failed data CRC and an unrecognised revision only raise warnings.

Each image begins with a `start_i` pulse. That pulse can also carry a total length from the surrounding logic, which the block then checks against the length held in the image.

Top module: `rom_hdr_check`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `fatal_o`, both warning flags and all field outputs read zero until the first completion.
- R2: Byte 0 must equal a CRC-8 over bytes 1..8. That CRC uses polynomial 0x07, initial value 0xFF, MSB-first processing and no final inversion. A mismatch sets `fatal_o`.
- R3: `uid_o` equals bytes 1..8 taken little-endian, so byte 1 is bits 7:0.
- R4: Bytes 9..12 hold a little-endian CRC-32C over the data region, which is bytes 13 through size-1. The CRC is reflected, uses polynomial 0x82F63B78, starts at all-ones and is inverted at the end. A mismatch sets `warn_data_o` and does not by itself set `fatal_o`.
- R5: The data length is the low 10 bits of the little-endian word in bytes 14..15; the upper 6 bits are ignored. `size_o` equals that length plus 13.
- R6: If the length in bytes 14..15 gives a size below 22, `done_o` pulses in the cycle after byte 15 is accepted, and `fatal_o` is set.
- R7: `rev_o` is byte 13. `vendor_o` is bytes 16..17 and `model_o` is bytes 18..19, both little-endian.
- R8: On a completion at full length, `warn_rev_o` is set exactly when the revision byte is greater than 2.
- R9: A byte flagged with `byte_last_i` before byte size-1 ends the image. `done_o` pulses in the next cycle and `fatal_o` is set.
- R10: If `len_chk_i` is high with `start_i`, a `len_total_i` value that differs from the size gives `fatal_o`. A matching value does not.
- R11: `done_o` is a one-cycle pulse in the cycle after the completing byte. Results hold until the next pulse. Bytes that arrive after completion and before the next `start_i` have no effect on any output.
- R12: `start_i` abandons any partial image and restarts at byte 0. A byte presented in the same cycle as `start_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new image at byte 0 |
| len_chk_i | input | 1 | Check `len_total_i` for this image (sampled with `start_i`) |
| len_total_i | input | SIZE_W | Externally known total image length |
| byte_valid_i | input | 1 | `byte_i` carries the next image byte |
| byte_i | input | 8 | Image byte |
| byte_last_i | input | 1 | This byte is the last one the stream will supply |
| done_o | output | 1 | One-cycle completion pulse |
| fatal_o | output | 1 | Image rejected |
| warn_data_o | output | 1 | Data CRC mismatch |
| warn_rev_o | output | 1 | Revision greater than 2 |
| uid_o | output | 64 | Unique identifier |
| vendor_o | output | 16 | Vendor ID |
| model_o | output | 16 | Model ID |
| rev_o | output | 8 | ROM revision byte |
| size_o | output | SIZE_W | Total image size in bytes |

## Verification
Some properties can be checked on every cycle. The assertions check that `done_o` never lasts two cycles and that results and flags change only on a completion pulse. They also check that an accepted image always reports a size of at least the header length, and that the revision warning matches the reported revision.

Other behaviour needs crafted images, and only the bench scenarios can show it. This covers the two CRC algorithms and their byte order, the masking of the length word, and truncated or short images. It also covers the external length comparison, restart mid-image and the dropping of trailing bytes.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  localparam int UID_FIRST  = 1;
  localparam int UID_LAST   = 8;
  localparam int DCRC_FIRST = 9;
  localparam int DATA_START = 13;
  localparam int LEN_LO     = 14;
  localparam int LEN_HI     = 15;
  localparam int VEN_LO     = 16;
  localparam int MOD_LO     = 18;
  localparam int HDR_BYTES  = 22;
  localparam int REV_MAX    = 2;

  // One byte of a non-reflected CRC-8, MSB first
  function automatic logic [7:0] crc8_byte(input logic [7:0] c,
                                           input logic [7:0] d,
                                           input logic [7:0] poly);
    logic [7:0] v;
    v = c ^ d;
    for (int b = 0; b < 8; b++)
      v = v[7] ? ((v << 1) ^ poly) : (v << 1);
    return v;
  endfunction

  // One byte of a reflected CRC-32, LSB first
  function automatic logic [31:0] crc32r_byte(input logic [31:0] c,
                                              input logic [7:0]  d,
                                              input logic [31:0] poly);
    logic [31:0] v;
    v = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++)
      v = v[0] ? ((v >> 1) ^ poly) : (v >> 1);
    return v;
  endfunction
endpackage

// File: rtl/rhc_crc8.sv
module rhc_crc8 #(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc_q
);
  import rhc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc_q <= INIT;
    else if (en)
      crc_q <= crc8_byte(crc_q, din, POLY);
  end
endmodule

// File: rtl/rhc_crc32c.sv
module rhc_crc32c #(
  parameter logic [31:0] POLY = 32'h82F63B78
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] res_next
);
  import rhc_pkg::*;

  logic [31:0] acc_q;
  logic [31:0] acc_d;

  always_comb begin
    acc_d    = en ? crc32r_byte(acc_q, din, POLY) : acc_q;
    res_next = ~acc_d;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc_q <= '1;
    else
      acc_q <= acc_d;
  end
endmodule

// File: rtl/rhc_hdr_fields.sv
module rhc_hdr_fields #(
  parameter int LEN_BITS = 10,
  parameter int IDX_W    = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [7:0]          din,
  output logic [7:0]          uid_crc_q,
  output logic [63:0]         uid_q,
  output logic [31:0]         dcrc_q,
  output logic [7:0]          rev_q,
  output logic [LEN_BITS-1:0] dlen_q,
  output logic [15:0]         ven_q,
  output logic [15:0]         mod_q
);
  import rhc_pkg::*;

  localparam int HI_BITS = LEN_BITS - 8;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      uid_crc_q <= '0;
      uid_q     <= '0;
      dcrc_q    <= '0;
      rev_q     <= '0;
      dlen_q    <= '0;
      ven_q     <= '0;
      mod_q     <= '0;
    end else if (en) begin
      if (idx == IDX_W'(0))
        uid_crc_q <= din;
      for (int k = 0; k < 8; k++)
        if (idx == IDX_W'(UID_FIRST + k))
          uid_q[8*k +: 8] <= din;
      for (int k = 0; k < 4; k++)
        if (idx == IDX_W'(DCRC_FIRST + k))
          dcrc_q[8*k +: 8] <= din;
      if (idx == IDX_W'(DATA_START))
        rev_q <= din;
      if (idx == IDX_W'(LEN_LO))
        dlen_q[7:0] <= din;
      if (idx == IDX_W'(LEN_HI))
        dlen_q[LEN_BITS-1:8] <= din[HI_BITS-1:0];
      for (int k = 0; k < 2; k++) begin
        if (idx == IDX_W'(VEN_LO + k))
          ven_q[8*k +: 8] <= din;
        if (idx == IDX_W'(MOD_LO + k))
          mod_q[8*k +: 8] <= din;
      end
    end
  end
endmodule

// File: rtl/rom_hdr_check.sv
module rom_hdr_check #(
  parameter int  LEN_BITS = 10,
  localparam int SIZE_W   = LEN_BITS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              len_chk_i,
  input  logic [SIZE_W-1:0] len_total_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_last_i,
  output logic              done_o,
  output logic              fatal_o,
  output logic              warn_data_o,
  output logic              warn_rev_o,
  output logic [63:0]       uid_o,
  output logic [15:0]       vendor_o,
  output logic [15:0]       model_o,
  output logic [7:0]        rev_o,
  output logic [SIZE_W-1:0] size_o
);
  import rhc_pkg::*;

  localparam int HI_BITS = LEN_BITS - 8;

  logic              active_q;
  logic [SIZE_W-1:0] idx_q;
  logic              lchk_q;
  logic [SIZE_W-1:0] ltot_q;

  logic              acc;
  logic [7:0]        uid_crc_q, crc8_q, rev_q;
  logic [63:0]       uid_q;
  logic [31:0]       dcrc_q, dcrc_calc;
  logic [LEN_BITS-1:0] dlen_q;
  logic [15:0]       ven_q, mod_q;
  logic [SIZE_W-1:0] size_now, size_at15;
  logic              short_img, full_end, finish, bad_fatal;

  assign acc = byte_valid_i && active_q && !start_i;

  rhc_crc8 #(.POLY(8'h07), .INIT(8'hFF)) crc8_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_i),
    .en    (acc && idx_q >= SIZE_W'(UID_FIRST) && idx_q <= SIZE_W'(UID_LAST)),
    .din   (byte_i),
    .crc_q (crc8_q)
  );

  rhc_crc32c #(.POLY(32'h82F63B78)) crc32_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_i),
    .en       (acc && idx_q >= SIZE_W'(DATA_START)),
    .din      (byte_i),
    .res_next (dcrc_calc)
  );

  rhc_hdr_fields #(.LEN_BITS(LEN_BITS), .IDX_W(SIZE_W)) fields_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_i),
    .en        (acc),
    .idx       (idx_q),
    .din       (byte_i),
    .uid_crc_q (uid_crc_q),
    .uid_q     (uid_q),
    .dcrc_q    (dcrc_q),
    .rev_q     (rev_q),
    .dlen_q    (dlen_q),
    .ven_q     (ven_q),
    .mod_q     (mod_q)
  );

  always_comb begin
    size_now  = SIZE_W'(dlen_q) + SIZE_W'(DATA_START);
    size_at15 = SIZE_W'({byte_i[HI_BITS-1:0], dlen_q[7:0]}) + SIZE_W'(DATA_START);
    short_img = acc && idx_q == SIZE_W'(LEN_HI) && size_at15 < SIZE_W'(HDR_BYTES);
    full_end  = acc && idx_q >= SIZE_W'(HDR_BYTES - 1) &&
                idx_q == size_now - SIZE_W'(1);
    finish    = acc && (byte_last_i || short_img || full_end);
    bad_fatal = !full_end || (crc8_q != uid_crc_q) ||
                (lchk_q && ltot_q != size_now);
  end

  // stream position and per-image options
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      lchk_q   <= 1'b0;
      ltot_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      lchk_q   <= len_chk_i;
      ltot_q   <= len_total_i;
    end else if (acc) begin
      idx_q <= idx_q + SIZE_W'(1);
      if (finish)
        active_q <= 1'b0;
    end
  end

  // registered results, updated only on completion
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      fatal_o     <= 1'b0;
      warn_data_o <= 1'b0;
      warn_rev_o  <= 1'b0;
      uid_o       <= '0;
      vendor_o    <= '0;
      model_o     <= '0;
      rev_o       <= '0;
      size_o      <= '0;
    end else begin
      done_o <= finish;
      if (finish) begin
        fatal_o     <= bad_fatal;
        warn_data_o <= full_end && (dcrc_calc != dcrc_q);
        warn_rev_o  <= full_end && (rev_q > 8'(REV_MAX));
        if (full_end) begin
          uid_o    <= uid_q;
          vendor_o <= ven_q;
          model_o  <= mod_q;
          rev_o    <= rev_q;
          size_o   <= size_now;
        end
      end
    end
  end
endmodule

// File: rtl/rhc_chk.sv
module rhc_chk #(
  parameter int SIZE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              done_o,
  input logic              fatal_o,
  input logic              warn_data_o,
  input logic              warn_rev_o,
  input logic [63:0]       uid_o,
  input logic [7:0]        rev_o,
  input logic [SIZE_W-1:0] size_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(uid_o) && $stable(size_o) && $stable(fatal_o) &&
                 $stable(warn_data_o) && $stable(warn_rev_o)));

  // R6
  min_size_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fatal_o) |-> (size_o >= SIZE_W'(22)));

  // R8
  rev_warn_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fatal_o) |-> (warn_rev_o == (rev_o > 8'd2)));

  // R8
  rev_warn_only_chk: assert property (@(posedge clk) disable iff (rst)
    warn_rev_o |-> (rev_o > 8'd2));
endmodule

bind rom_hdr_check rhc_chk #(.SIZE_W(SIZE_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .done_o      (done_o),
  .fatal_o     (fatal_o),
  .warn_data_o (warn_data_o),
  .warn_rev_o  (warn_rev_o),
  .uid_o       (uid_o),
  .rev_o       (rev_o),
  .size_o      (size_o)
);

// File: tb/rom_hdr_check_tb_top.sv
`timescale 1ns/1ps
module rom_hdr_check_tb_top;
  localparam int SW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, len_chk_i = 1'b0;
  logic [SW-1:0] len_total_i = '0;
  logic byte_valid_i = 1'b0, byte_last_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic done_o, fatal_o, warn_data_o, warn_rev_o;
  logic [63:0] uid_o;
  logic [15:0] vendor_o, model_o;
  logic [7:0] rev_o;
  logic [SW-1:0] size_o;

  always #4 clk = ~clk;

  rom_hdr_check dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .len_chk_i(len_chk_i),
    .len_total_i(len_total_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .byte_last_i(byte_last_i), .done_o(done_o), .fatal_o(fatal_o),
    .warn_data_o(warn_data_o), .warn_rev_o(warn_rev_o), .uid_o(uid_o),
    .vendor_o(vendor_o), .model_o(model_o), .rev_o(rev_o), .size_o(size_o)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R2";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_crc8(logic [7:0] q[$]);
    logic [7:0] c = 8'hFF;
    for (int i = 1; i <= 8; i++) begin
      c ^= q[i];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] f_crc32c(logic [7:0] q[$], int first, int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = first; i < first + n; i++) begin
      c ^= {24'd0, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    end
    return ~c;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_q[$];
  bit m_active = 0, m_lchk = 0;
  int m_ltot = 0;
  bit e_done = 0, e_fatal = 0, e_wd = 0, e_wr = 0, e_full = 0;
  logic [63:0] e_uid = 0;
  logic [15:0] e_ven = 0, e_mod = 0;
  logic [7:0] e_rev = 0;
  int e_size = 0;

  always @(posedge clk) begin
    bit fin;
    fin = 0;
    if (rst) begin
      m_q.delete(); m_active = 0;
    end else if (start_i) begin
      m_q.delete(); m_active = 1; m_lchk = len_chk_i; m_ltot = int'(len_total_i);
    end else if (byte_valid_i && m_active) begin
      int n, sz;
      m_q.push_back(byte_i);
      n  = m_q.size();
      sz = (n >= 16) ? ({m_q[15][1:0], m_q[14]} + 13) : 0;
      if (byte_last_i || (n == 16 && sz < 22) || (n >= 22 && n == sz)) begin
        fin = 1; m_active = 0;
        e_full = (n >= 22 && n == sz);
        e_fatal = !e_full;
        if (e_full) begin
          if (f_crc8(m_q) != m_q[0]) e_fatal = 1;
          if (m_lchk && m_ltot != sz) e_fatal = 1;
          e_wd   = f_crc32c(m_q, 13, sz - 13) != {m_q[12], m_q[11], m_q[10], m_q[9]};
          e_wr   = m_q[13] > 2;
          e_uid  = {m_q[8], m_q[7], m_q[6], m_q[5], m_q[4], m_q[3], m_q[2], m_q[1]};
          e_ven  = {m_q[17], m_q[16]};
          e_mod  = {m_q[19], m_q[18]};
          e_rev  = m_q[13];
          e_size = sz;
        end else begin
          e_wd = 0; e_wr = 0;
        end
      end
    end
    e_done = fin;
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 done", done_o, e_done);
      if (e_done) begin
        chk(cur_req, fatal_o, e_fatal);
        chk("R4 warn_data", warn_data_o, e_wd);
        chk("R8 warn_rev", warn_rev_o, e_wr);
        if (e_full) begin
          chk("R3 uid", uid_o, e_uid);
          chk("R7 vendor", vendor_o, e_ven);
          chk("R7 model", model_o, e_mod);
          chk("R7 rev", rev_o, e_rev);
          chk("R5 size", size_o, e_size);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] img[$];

  task automatic make_img(int dlen, logic [7:0] rev, logic [15:0] ven,
                          logic [15:0] mdl, logic [63:0] uid, bit bad8, bit bad32);
    int sz, tot;
    logic [31:0] c;
    sz  = dlen + 13;
    tot = (sz < 22) ? 22 : sz;
    img.delete();
    for (int i = 0; i < tot; i++) img.push_back(8'((i * 37 + dlen) ^ 8'h5A));
    for (int k = 0; k < 8; k++) img[1 + k] = uid[8*k +: 8];
    img[13] = rev;
    img[14] = dlen[7:0];
    img[15] = {6'b101101, dlen[9:8]};
    img[16] = ven[7:0]; img[17] = ven[15:8];
    img[18] = mdl[7:0]; img[19] = mdl[15:8];
    if (sz >= 22) begin
      c = f_crc32c(img, 13, dlen) ^ (bad32 ? 32'h1 : 32'h0);
      for (int k = 0; k < 4; k++) img[9 + k] = c[8*k +: 8];
    end
    img[0] = f_crc8(img) ^ (bad8 ? 8'h01 : 8'h00);
  endtask

  task automatic send(int n, bit use_last, bit lchk, int ltot, bit with_start,
                      bit byte_on_start);
    if (with_start) begin
      @(negedge clk);
      start_i = 1; len_chk_i = lchk; len_total_i = SW'(ltot);
      byte_valid_i = byte_on_start; byte_i = 8'hEE; byte_last_i = 0;
      @(negedge clk);
      start_i = 0; len_chk_i = 0;
      byte_valid_i = 0;
    end
    for (int i = 0; i < n; i++) begin
      byte_valid_i = 1; byte_i = img[i];
      byte_last_i = use_last && (i == n - 1);
      @(negedge clk);
    end
    byte_valid_i = 0; byte_last_i = 0;
    repeat (2) @(negedge clk);
  endtask

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep_uid;
    repeat (3) @(negedge clk);
    // R1 reset state while held and after release
    chk("R1 done", done_o, 0);
    chk("R1 fatal", fatal_o, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 uid", uid_o, 0);
    chk("R1 size", size_o, 0);
    chk("R1 warn", {warn_data_o, warn_rev_o}, 0);

    // good minimum image
    cur_req = "R2 fatal";
    make_img(9, 8'd1, 16'h8086, 16'h1234, 64'h0102_0304_0506_0708, 0, 0);
    send(22, 1, 0, 0, 1, 0);
    chk("R2 good fatal", fatal_o, 0);
    chk("R5 size22", size_o, 22);
    chk("R3 uid", uid_o, 64'h0102_0304_0506_0708);

    // longer image, unknown revision
    cur_req = "R8 fatal";
    make_img(40, 8'd3, 16'hABCD, 16'h0F0E, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);
    send(53, 0, 0, 0, 1, 0);
    chk("R8 rev3 warn", warn_rev_o, 1);
    chk("R5 size53", size_o, 53);
    chk("R7 vendor", vendor_o, 16'hABCD);

    // maximum length, revision 2 accepted
    cur_req = "R5 fatal";
    make_img(1023, 8'd2, 16'h1111, 16'h2222, 64'h1, 0, 0);
    send(1036, 1, 0, 0, 1, 0);
    chk("R5 size1036", size_o, 1036);
    chk("R8 rev2 nowarn", warn_rev_o, 0);

    // data CRC mismatch is only a warning
    cur_req = "R4 fatal";
    make_img(30, 8'd0, 16'h3333, 16'h4444, 64'h55AA_55AA_0000_FFFF, 0, 1);
    send(43, 1, 0, 0, 1, 0);
    chk("R4 warn", warn_data_o, 1);
    chk("R4 not fatal", fatal_o, 0);

    // uid CRC mismatch is fatal
    cur_req = "R2 fatal";
    make_img(12, 8'd1, 16'h5555, 16'h6666, 64'h7777_8888_9999_AAAA, 1, 0);
    send(25, 1, 0, 0, 1, 0);
    chk("R2 bad crc8", fatal_o, 1);

    // short image: size 18
    cur_req = "R6 fatal";
    make_img(5, 8'd1, 16'h0, 16'h0, 64'h42, 0, 0);
    send(22, 0, 0, 0, 1, 0);
    chk("R6 short", fatal_o, 1);

    // truncated stream
    cur_req = "R9 fatal";
    make_img(30, 8'd1, 16'h0101, 16'h0202, 64'h99, 0, 0);
    send(25, 1, 0, 0, 1, 0);
    chk("R9 truncated", fatal_o, 1);

    // external length mismatch then match
    cur_req = "R10 fatal";
    make_img(20, 8'd1, 16'h0A0A, 16'h0B0B, 64'hA5A5, 0, 0);
    send(33, 1, 1, 34, 1, 0);
    chk("R10 mismatch", fatal_o, 1);
    send(33, 1, 1, 33, 1, 0);
    chk("R10 match", fatal_o, 0);

    // trailing bytes without start are ignored
    keep_uid = uid_o;
    send(4, 1, 0, 0, 0, 0);
    chk("R11 ignored uid", uid_o, keep_uid);
    chk("R11 ignored fatal", fatal_o, 0);

    // restart mid-image, start cycle byte dropped
    cur_req = "R12 fatal";
    make_img(15, 8'd1, 16'hC0C0, 16'hD0D0, 64'h1357_9BDF_2468_ACE0, 0, 0);
    send(10, 0, 0, 0, 1, 0);
    make_img(10, 8'd0, 16'hE0E0, 16'hF0F0, 64'h0FED_CBA9_8765_4321, 0, 0);
    send(23, 1, 0, 0, 1, 1);
    chk("R12 uid", uid_o, 64'h0FED_CBA9_8765_4321);
    chk("R12 fatal", fatal_o, 0);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule